// File: doc/BRIEF.md
# JTAG Virtual Instruction Hub

This block sits behind a JTAG TAP controller and lets several user logic nodes share the two user scan paths of the device. It watches the TAP state strobes, TDI and the 10-bit instruction currently held by the TAP. While the instruction-select code is loaded, every DR scan runs through one fixed-length shift register. That register holds a node address in its upper bits and a virtual instruction value in its lower bits. On Update-DR the value goes to the addressed node, and the address is kept.

While the data-select code is loaded, the kept address steers DR scans. The shift, capture and update strobes go only to that node, and TDO is taken from that node's TDO. Address 0 belongs to the hub. It has its own 4-bit virtual instruction and a one-bit bypass register for data scans. Nodes are numbered from 1 upward. The value field is as wide as the widest node instruction, and never narrower than 4 bits. A node with a narrower instruction keeps only its low bits.

Top module: `vjh_hub`

## Requirements
- R1: When the instruction equals 10'h00E (instruction-select), a TCK edge in Shift-DR moves the shift register one place toward bit 0. TDI enters at the MSB. tdo_o equals bit 0 and tdo_en_o is high.
- R2: On Update-DR under 10'h00E, the top ADDR_W bits of the shift register become the stored address. The low VIR_W bits are written to the node at that address (1..NUM_NODES). Bits at or above that node's own instruction width are stored as zero.
- R3: An update to address 0 writes the hub's own 4-bit instruction and leaves every node output unchanged. An update to an address above NUM_NODES writes no instruction.
- R4: On Capture-DR under 10'h00E, the shift register loads the stored address above the current instruction of that address, zero-extended. For an address above NUM_NODES the instruction part is zero.
- R5: When the instruction equals 10'h00C (data-select) and the stored address is a node, the shift, capture and update strobes follow the TAP strobes on that node's bit only. tdo_o equals that node's TDO.
- R6: Under 10'h00C with stored address 0 or above NUM_NODES, no node strobe rises. tdo_o comes from a one-bit bypass that captures 0 and shifts TDI.
- R7: Under any other instruction, all node strobes are low, tdo_en_o is low and tdo_o is 0.
- R8: rst_ni low, or a TCK edge with tlr_i high, clears the stored address, the hub instruction and all node instructions to zero.
- R9: Node instructions change only on an Update-DR under 10'h00E or on a Test-Logic-Reset. Capture and shift do not alter them.
- R10: Update-DR under 10'h00C does not change the stored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | JTAG test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tlr_i | input | 1 | TAP in Test-Logic-Reset |
| ir_i | input | IR_W | Instruction currently held by the TAP |
| capture_dr_i | input | 1 | TAP in Capture-DR |
| shift_dr_i | input | 1 | TAP in Shift-DR |
| update_dr_i | input | 1 | TAP in Update-DR |
| tdi_i | input | 1 | Test data in |
| node_tdo_i | input | NUM_NODES | Serial output of each node's data register |
| node_vir_o | output | NUM_NODES*VIR_W | Virtual instruction of each node, node 1 in the low slice |
| node_capture_o | output | NUM_NODES | Capture strobe per node |
| node_shift_o | output | NUM_NODES | Shift strobe per node |
| node_update_o | output | NUM_NODES | Update strobe per node |
| tdo_o | output | 1 | Test data out |
| tdo_en_o | output | 1 | Hub drives TDO |

## Verification
The bench writes to a node whose instruction is narrower than the field. If the upper bits were not masked, the node would read them as a wider instruction. It writes to address 0 and to an unused address. A hub that decoded those writes wrongly would change a node's instruction. It reads the word back with a capture-and-shift. A wrong bit order or a wrong capture source would return a rotated word or one with the wrong address. It counts strobe pulses during data scans on each node and on the bypass. A design that decoded the address loosely would send pulses to the wrong node. A design that let an update under the data-select code reload the address would also be caught here, as would strobes or TDO leaking out under an unrelated instruction.

// File: rtl/vjh_pkg.sv
package vjh_pkg;
  typedef enum logic [1:0] {
    PATH_NONE = 2'd0,
    PATH_VIR  = 2'd1,
    PATH_VDR  = 2'd2
  } path_e;

  localparam int unsigned HUB_VIR_W = 4;
endpackage

// File: rtl/vjh_decode.sv
module vjh_decode
  import vjh_pkg::*;
#(
  parameter int unsigned IR_W       = 10,
  parameter logic [IR_W-1:0] SEL_CODE = IR_W'(10'h00E),
  parameter logic [IR_W-1:0] DAT_CODE = IR_W'(10'h00C)
) (
  input  logic [IR_W-1:0] ir_i,
  output path_e           path_o
);
  always_comb begin
    if (ir_i == SEL_CODE)      path_o = PATH_VIR;
    else if (ir_i == DAT_CODE) path_o = PATH_VDR;
    else                       path_o = PATH_NONE;
  end
endmodule

// File: rtl/vjh_vir_sr.sv
module vjh_vir_sr #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned VIR_W  = 6,
  localparam int unsigned SR_W  = ADDR_W + VIR_W
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tlr_i,
  input  logic            en_i,
  input  logic            capture_i,
  input  logic            shift_i,
  input  logic            tdi_i,
  input  logic [SR_W-1:0] cap_word_i,
  output logic [SR_W-1:0] sr_o
);
  logic [SR_W-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                sr_q <= '0;
    else if (tlr_i)             sr_q <= '0;
    else if (en_i && capture_i) sr_q <= cap_word_i;
    else if (en_i && shift_i)   sr_q <= {tdi_i, sr_q[SR_W-1:1]};
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/vjh_vir_bank.sv
module vjh_vir_bank
  import vjh_pkg::*;
#(
  parameter int unsigned NUM_NODES = 2,
  parameter int unsigned NODE_IRW [NUM_NODES] = '{3, 6},
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned VIR_W  = 6
) (
  input  logic                       tck_i,
  input  logic                       rst_ni,
  input  logic                       tlr_i,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [VIR_W-1:0]           wr_val_i,
  output logic [ADDR_W-1:0]          addr_o,
  output logic [NUM_NODES*VIR_W-1:0] node_vir_o,
  output logic [VIR_W-1:0]           rd_val_o
);
  logic [ADDR_W-1:0]    addr_q;
  logic [HUB_VIR_W-1:0] hub_vir_q;
  logic [VIR_W-1:0]     vir_q [NUM_NODES];

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      hub_vir_q <= '0;
    end else if (tlr_i) begin
      addr_q    <= '0;
      hub_vir_q <= '0;
    end else if (wr_i) begin
      addr_q <= wr_addr_i;
      if (wr_addr_i == '0) hub_vir_q <= wr_val_i[HUB_VIR_W-1:0];
    end
  end

  for (genvar k = 0; k < NUM_NODES; k++) begin : g_node
    // node keeps only its own instruction width
    localparam logic [VIR_W-1:0] MASK = {VIR_W{1'b1}} >> (VIR_W - NODE_IRW[k]);

    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)                                    vir_q[k] <= '0;
      else if (tlr_i)                                 vir_q[k] <= '0;
      else if (wr_i && wr_addr_i == ADDR_W'(k + 1))   vir_q[k] <= wr_val_i & MASK;
    end

    assign node_vir_o[k*VIR_W +: VIR_W] = vir_q[k];
  end

  always_comb begin
    rd_val_o = '0;
    if (addr_q == '0) rd_val_o = VIR_W'(hub_vir_q);
    for (int k = 0; k < NUM_NODES; k++) begin
      if (addr_q == ADDR_W'(k + 1)) rd_val_o = vir_q[k];
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/vjh_route.sv
module vjh_route
  import vjh_pkg::*;
#(
  parameter int unsigned NUM_NODES = 2,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic                 tck_i,
  input  logic                 rst_ni,
  input  logic                 tlr_i,
  input  path_e                path_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 capture_i,
  input  logic                 shift_i,
  input  logic                 update_i,
  input  logic                 tdi_i,
  input  logic                 sr_lsb_i,
  input  logic [NUM_NODES-1:0] node_tdo_i,
  output logic [NUM_NODES-1:0] node_capture_o,
  output logic [NUM_NODES-1:0] node_shift_o,
  output logic [NUM_NODES-1:0] node_update_o,
  output logic                 tdo_o,
  output logic                 tdo_en_o
);
  logic [NUM_NODES-1:0] hit;
  logic                 any_hit;
  logic                 vdr;
  logic                 byp_q;

  for (genvar k = 0; k < NUM_NODES; k++) begin : g_hit
    assign hit[k] = (addr_i == ADDR_W'(k + 1));
  end

  assign any_hit = |hit;
  assign vdr     = (path_i == PATH_VDR);

  assign node_capture_o = (vdr && capture_i) ? hit : '0;
  assign node_shift_o   = (vdr && shift_i)   ? hit : '0;
  assign node_update_o  = (vdr && update_i)  ? hit : '0;

  // one-bit bypass for the hub's own data path
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                          byp_q <= 1'b0;
    else if (tlr_i)                       byp_q <= 1'b0;
    else if (vdr && !any_hit && capture_i) byp_q <= 1'b0;
    else if (vdr && !any_hit && shift_i)   byp_q <= tdi_i;
  end

  always_comb begin
    unique case (path_i)
      PATH_VIR: tdo_o = sr_lsb_i;
      PATH_VDR: tdo_o = any_hit ? |(node_tdo_i & hit) : byp_q;
      default:  tdo_o = 1'b0;
    endcase
  end

  assign tdo_en_o = (path_i != PATH_NONE);
endmodule

// File: rtl/vjh_hub.sv
module vjh_hub
  import vjh_pkg::*;
#(
  parameter int unsigned NUM_NODES = 2,
  parameter int unsigned NODE_IRW [NUM_NODES] = '{3, 6},
  parameter int unsigned IR_W = 10,
  parameter logic [IR_W-1:0] SEL_CODE = IR_W'(10'h00E),
  parameter logic [IR_W-1:0] DAT_CODE = IR_W'(10'h00C),
  localparam int unsigned ADDR_W = $clog2(NUM_NODES + 1),
  localparam int unsigned VIR_W  = vir_width(),
  localparam int unsigned SR_W   = ADDR_W + VIR_W
) (
  input  logic                       tck_i,
  input  logic                       rst_ni,
  input  logic                       tlr_i,
  input  logic [IR_W-1:0]            ir_i,
  input  logic                       capture_dr_i,
  input  logic                       shift_dr_i,
  input  logic                       update_dr_i,
  input  logic                       tdi_i,
  input  logic [NUM_NODES-1:0]       node_tdo_i,
  output logic [NUM_NODES*VIR_W-1:0] node_vir_o,
  output logic [NUM_NODES-1:0]       node_capture_o,
  output logic [NUM_NODES-1:0]       node_shift_o,
  output logic [NUM_NODES-1:0]       node_update_o,
  output logic                       tdo_o,
  output logic                       tdo_en_o
);
  function automatic int unsigned vir_width();
    int unsigned m = HUB_VIR_W;
    for (int i = 0; i < NUM_NODES; i++) if (NODE_IRW[i] > m) m = NODE_IRW[i];
    return m;
  endfunction

  path_e             path;
  logic [SR_W-1:0]   sr;
  logic [ADDR_W-1:0] addr;
  logic [VIR_W-1:0]  rd_val;
  logic              vir_path;

  assign vir_path = (path == PATH_VIR);

  vjh_decode #(
    .IR_W(IR_W), .SEL_CODE(SEL_CODE), .DAT_CODE(DAT_CODE)
  ) u_dec (
    .ir_i(ir_i), .path_o(path)
  );

  vjh_vir_sr #(
    .ADDR_W(ADDR_W), .VIR_W(VIR_W)
  ) u_sr (
    .tck_i(tck_i), .rst_ni(rst_ni), .tlr_i(tlr_i), .en_i(vir_path),
    .capture_i(capture_dr_i), .shift_i(shift_dr_i), .tdi_i(tdi_i),
    .cap_word_i({addr, rd_val}), .sr_o(sr)
  );

  vjh_vir_bank #(
    .NUM_NODES(NUM_NODES), .NODE_IRW(NODE_IRW), .ADDR_W(ADDR_W), .VIR_W(VIR_W)
  ) u_bank (
    .tck_i(tck_i), .rst_ni(rst_ni), .tlr_i(tlr_i),
    .wr_i(vir_path && update_dr_i),
    .wr_addr_i(sr[SR_W-1 -: ADDR_W]), .wr_val_i(sr[VIR_W-1:0]),
    .addr_o(addr), .node_vir_o(node_vir_o), .rd_val_o(rd_val)
  );

  vjh_route #(
    .NUM_NODES(NUM_NODES), .ADDR_W(ADDR_W)
  ) u_route (
    .tck_i(tck_i), .rst_ni(rst_ni), .tlr_i(tlr_i), .path_i(path), .addr_i(addr),
    .capture_i(capture_dr_i), .shift_i(shift_dr_i), .update_i(update_dr_i),
    .tdi_i(tdi_i), .sr_lsb_i(sr[0]), .node_tdo_i(node_tdo_i),
    .node_capture_o(node_capture_o), .node_shift_o(node_shift_o),
    .node_update_o(node_update_o), .tdo_o(tdo_o), .tdo_en_o(tdo_en_o)
  );
endmodule

// File: rtl/vjh_hub_chk.sv
module vjh_hub_chk #(
  parameter int unsigned NUM_NODES = 2,
  parameter int unsigned IR_W = 10,
  parameter int unsigned VW   = 6,
  parameter logic [IR_W-1:0] SEL_CODE = IR_W'(10'h00E),
  parameter logic [IR_W-1:0] DAT_CODE = IR_W'(10'h00C)
) (
  input logic                    tck_i,
  input logic                    rst_ni,
  input logic                    tlr_i,
  input logic [IR_W-1:0]         ir_i,
  input logic                    update_dr_i,
  input logic [NUM_NODES*VW-1:0] node_vir_o,
  input logic [NUM_NODES-1:0]    node_capture_o,
  input logic [NUM_NODES-1:0]    node_shift_o,
  input logic [NUM_NODES-1:0]    node_update_o,
  input logic                    tdo_o,
  input logic                    tdo_en_o
);
  // R7
  idle_quiet_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir_i != SEL_CODE && ir_i != DAT_CODE) |->
      (node_shift_o == '0 && node_capture_o == '0 && node_update_o == '0 && !tdo_en_o && !tdo_o));

  // R5
  one_shift_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0(node_shift_o) && $onehot0(node_capture_o) && $onehot0(node_update_o));

  // R1
  sel_drive_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir_i == SEL_CODE) |-> tdo_en_o);

  // R8
  tlr_clear_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (node_vir_o == '0));

  // R9
  vir_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!tlr_i && !(ir_i == SEL_CODE && update_dr_i)) |=> $stable(node_vir_o));
endmodule

bind vjh_hub vjh_hub_chk #(
  .NUM_NODES(NUM_NODES), .IR_W(IR_W), .VW(VIR_W), .SEL_CODE(SEL_CODE), .DAT_CODE(DAT_CODE)
) u_chk (
  .tck_i(tck_i), .rst_ni(rst_ni), .tlr_i(tlr_i), .ir_i(ir_i), .update_dr_i(update_dr_i),
  .node_vir_o(node_vir_o), .node_capture_o(node_capture_o), .node_shift_o(node_shift_o),
  .node_update_o(node_update_o), .tdo_o(tdo_o), .tdo_en_o(tdo_en_o)
);

// File: tb/sim_vjh_hub.sv
`timescale 1ns/1ps
module sim_vjh_hub;
  localparam int NN = 2, VW = 6, AW = 2, SW = 8;
  localparam logic [9:0] SEL = 10'h00E, DAT = 10'h00C;

  logic tck = 0, rst_n = 0, tlr = 0, cap = 0, sh = 0, up = 0, tdi = 0;
  logic [9:0] ir = 10'h3FF;
  logic [NN-1:0] ntdo = '0;
  logic [NN*VW-1:0] node_vir;
  logic [NN-1:0] ncap, nsh, nup;
  logic tdo, tdo_en;

  vjh_hub u0 (
    .tck_i(tck), .rst_ni(rst_n), .tlr_i(tlr), .ir_i(ir), .capture_dr_i(cap),
    .shift_dr_i(sh), .update_dr_i(up), .tdi_i(tdi), .node_tdo_i(ntdo),
    .node_vir_o(node_vir), .node_capture_o(ncap), .node_shift_o(nsh),
    .node_update_o(nup), .tdo_o(tdo), .tdo_en_o(tdo_en)
  );

  always #5 tck = ~tck;

  int errs = 0, checks = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [SW-1:0] m_sr;
  int            m_addr;
  logic [3:0]    m_hub;
  logic [VW-1:0] m_vir [NN];
  logic          m_byp;
  int            ma;
  logic [VW-1:0] mv;

  function automatic logic [VW-1:0] m_rd();
    if (m_addr == 0) return VW'(m_hub);
    if (m_addr == 1) return m_vir[0];
    if (m_addr == 2) return m_vir[1];
    return '0;
  endfunction

  function automatic bit m_sel();
    return (m_addr == 1 || m_addr == 2);
  endfunction

  always @(posedge tck or negedge rst_n) begin
    if (!rst_n || tlr) begin
      m_sr = '0; m_addr = 0; m_hub = '0; m_vir[0] = '0; m_vir[1] = '0; m_byp = 0;
    end else begin
      if (ir == SEL && cap) m_sr = {AW'(m_addr), m_rd()};
      else if (ir == SEL && sh) m_sr = {tdi, m_sr[SW-1:1]};
      else if (ir == SEL && up) begin
        ma = int'(m_sr[SW-1 -: AW]); mv = m_sr[VW-1:0]; m_addr = ma;
        if (ma == 0) m_hub = mv[3:0];
        else if (ma == 1) m_vir[0] = mv & 6'h07;
        else if (ma == 2) m_vir[1] = mv;
      end
      if (ir == DAT && !m_sel()) begin
        if (cap) m_byp = 0;
        else if (sh) m_byp = tdi;
      end
    end
  end

  always @(posedge tck) begin
    #2;
    ntdo = NN'($urandom);
  end

  // per-clock comparison
  int sh_cnt [NN];
  int up_cnt [NN];
  always @(negedge tck) begin
    logic [NN-1:0] es, ec, eu;
    logic et;
    if (rst_n) begin
      chk("R2/R9 node_vir", 64'(node_vir), 64'({m_vir[1], m_vir[0]}));
      es = '0; ec = '0; eu = '0;
      if (ir == DAT && m_sel()) begin
        if (sh)  es = NN'(1) << (m_addr - 1);
        if (cap) ec = NN'(1) << (m_addr - 1);
        if (up)  eu = NN'(1) << (m_addr - 1);
      end
      chk((ir == DAT) ? "R5/R6 strobes" : "R7 strobes", 64'({nsh, ncap, nup}), 64'({es, ec, eu}));
      chk("R7 tdo_en", 64'(tdo_en), 64'(ir == SEL || ir == DAT));
      if (ir == SEL) et = m_sr[0];
      else if (ir == DAT) et = m_sel() ? ntdo[m_addr-1] : m_byp;
      else et = 1'b0;
      chk((ir == SEL) ? "R1 tdo" : (ir == DAT) ? "R5/R6 tdo" : "R7 tdo", 64'(tdo), 64'(et));
      for (int k = 0; k < NN; k++) begin
        if (nsh[k]) sh_cnt[k]++;
        if (nup[k]) up_cnt[k]++;
      end
    end
  end

  task automatic step(input logic c, input logic s, input logic u, input logic d);
    cap = c; sh = s; up = u; tdi = d;
    @(posedge tck); #1;
    cap = 0; sh = 0; up = 0;
  endtask

  task automatic vir_write(input int a, input logic [VW-1:0] v);
    logic [SW-1:0] w;
    w = {AW'(a), v};
    ir = SEL;
    step(1, 0, 0, 0);
    for (int i = 0; i < SW; i++) step(0, 1, 0, w[i]);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
  endtask

  task automatic readback(output logic [SW-1:0] r);
    ir = SEL;
    step(1, 0, 0, 0);
    for (int i = 0; i < SW; i++) begin
      r[i] = tdo;
      step(0, 1, 0, r[i]);
    end
    step(0, 0, 0, 0);
  endtask

  task automatic data_scan(input int len, input logic do_up);
    ir = DAT;
    step(1, 0, 0, 0);
    for (int i = 0; i < len; i++) step(0, 1, 0, 1'(i));
    if (do_up) step(0, 0, 1, 0);
    step(0, 0, 0, 0);
  endtask

  task automatic clr_cnt();
    for (int k = 0; k < NN; k++) begin sh_cnt[k] = 0; up_cnt[k] = 0; end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [SW-1:0] rb;
    clr_cnt();
    repeat (3) @(posedge tck);
    #1 rst_n = 1;
    @(posedge tck); #1;
    // R8 reset state
    chk("R8 reset vir", 64'(node_vir), 64'(0));
    chk("R8 reset tdo_en", 64'(tdo_en), 64'(0));

    // R2: narrow node masks upper bits
    vir_write(1, 6'h3F);
    chk("R2 node1 masked", 64'(node_vir[VW-1:0]), 64'h07);
    vir_write(2, 6'h2A);
    chk("R2 node2 full", 64'(node_vir[2*VW-1:VW]), 64'h2A);

    // R4 readback of node 2
    readback(rb);
    chk("R4 readback node2", 64'(rb), 64'({2'd2, 6'h2A}));

    // R3 hub write and unused address
    vir_write(0, 6'h15);
    chk("R3 hub write leaves nodes", 64'(node_vir), 64'({6'h2A, 6'h07}));
    readback(rb);
    chk("R3/R4 readback hub", 64'(rb), 64'({2'd0, 6'h05}));
    vir_write(3, 6'h11);
    chk("R3 unused addr leaves nodes", 64'(node_vir), 64'({6'h2A, 6'h07}));
    readback(rb);
    chk("R4 readback unused", 64'(rb), 64'({2'd3, 6'h00}));

    // R6 bypass data scan on unused address
    clr_cnt();
    data_scan(5, 1);
    chk("R6 no node shift", 64'(sh_cnt[0] + sh_cnt[1]), 64'(0));
    chk("R6 no node update", 64'(up_cnt[0] + up_cnt[1]), 64'(0));

    // R5 data scan on node 2
    vir_write(2, 6'h0B);
    clr_cnt();
    data_scan(7, 1);
    chk("R5 node2 shifts", 64'(sh_cnt[1]), 64'(7));
    chk("R5 node1 quiet", 64'(sh_cnt[0]), 64'(0));
    chk("R5 node2 update", 64'(up_cnt[1]), 64'(1));

    // R10 data update keeps address
    readback(rb);
    chk("R10 address kept", 64'(rb[SW-1 -: AW]), 64'(2));

    // R5 node 1 path
    vir_write(1, 6'h02);
    clr_cnt();
    data_scan(3, 0);
    chk("R5 node1 shifts", 64'(sh_cnt[0]), 64'(3));

    // R9 shifting under select path without update
    ir = SEL;
    step(1, 0, 0, 0);
    for (int i = 0; i < SW; i++) step(0, 1, 0, 1'b1);
    step(0, 0, 0, 0);
    chk("R9 no update no change", 64'(node_vir), 64'({6'h0B, 6'h02}));

    // R7 unrelated instruction
    ir = 10'h3FF;
    clr_cnt();
    step(1, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1'b1);
    step(0, 0, 1, 0);
    chk("R7 no strobes", 64'(sh_cnt[0] + sh_cnt[1] + up_cnt[0] + up_cnt[1]), 64'(0));
    chk("R7 vir held", 64'(node_vir), 64'({6'h0B, 6'h02}));

    // R8 Test-Logic-Reset
    tlr = 1;
    step(0, 0, 0, 0);
    tlr = 0;
    chk("R8 tlr clears vir", 64'(node_vir), 64'(0));
    readback(rb);
    chk("R8 tlr clears address", 64'(rb), 64'(0));

    repeat (2) @(posedge tck);
    finish_run();
  end
endmodule